// File: doc/BRIEF.md
# Command-Macro Arithmetic Unit

This block is the arithmetic and logic stage of a small processor that runs command macros. Each cycle it decodes a 32-bit instruction word held at its input, combines two 32-bit register operands A and B, and presents a 32-bit result. It also keeps a single carry flag for multi-word arithmetic. The instruction fetch, the register file and branch handling belong to the surrounding sequencer. That sequencer holds the instruction and operands steady until the result is marked valid.

The unit covers four families of work. The register-to-register group has add, add with carry, subtract, subtract with borrow and five logic functions. Add-immediate uses a signed 18-bit immediate. Three bitfield operations take their bit positions from instruction fields. A register read fetches from address A plus the immediate over a valid/ready request followed by a data-return strobe. An opcode or sub-operation the unit does not support raises an error flag, and no valid result is produced for it.

Top module: `macro_alu`

## Requirements
- R1: The primary operation sits in instruction bits [2:0]: 0 register-register, 1 add immediate, 2 bitfield insert, 3 extract with left shift by field, 4 extract with left shift by A, 5 register read. Codes 6 and 7 drive error_o high and result_valid_o low.
- R2: With primary operation 0, the sub-operation is in bits [21:17]. The codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 8 XOR, 9 OR, 10 AND, 11 A AND NOT B, 12 NOT(A AND B). Any other code drives error_o high and result_valid_o low.
- R3: Add and add-with-carry produce the low 32 bits of the sum, with the carry flag as the incoming carry term. The new carry is bit 32 of the 33-bit unsigned sum.
- R4: Subtract gives A-B. Subtract with borrow gives A-B-1 when the carry flag is clear, and A-B when it is set. The new carry is 1 exactly when the unsigned difference does not go below zero.
- R5: The five logic sub-operations give their bitwise results and leave carry_o unchanged.
- R6: carry_o is 0 after reset. It changes only on a clock edge where carry_en_i is high and a valid arithmetic sub-operation (codes 0 to 3) is decoded.
- R7: Add immediate returns A plus the sign extension of instruction bits [31:14], modulo 2^32.
- R8: The field source position is bits [21:17], the size is bits [26:22] and the destination position is bits [31:27], with mask = (1<<size)-1. Bitfield insert places (B>>source)&mask at the destination position of A and keeps every other bit of A.
- R9: Extract with shift by field returns ((B >> A[4:0]) & mask) << destination. The right shift is logical.
- R10: Extract with shift by A returns ((B >> source) & mask) << A[4:0].
- R11: For a register read, rd_req_valid_o is high with rd_addr_o = A + sign-extended immediate until the cycle rd_req_ready_i is sampled high. It is then low until rd_data_valid_i. In that cycle result_o equals rd_data_i and result_valid_o is high. Before that, result_valid_o stays low.
- R12: Every non-read operation without an error gives result_valid_o high in the same cycle its inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_i | input | 32 | Instruction word |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| carry_en_i | input | 1 | Clock enable for the carry flag |
| result_o | output | 32 | Operation result |
| result_valid_o | output | 1 | Result is valid this cycle |
| error_o | output | 1 | Unsupported operation decoded |
| carry_o | output | 1 | Carry flag |
| rd_req_valid_o | output | 1 | Register-read request valid |
| rd_req_ready_i | input | 1 | Register-read request accepted |
| rd_addr_o | output | RD_ADDR_W | Register-read address |
| rd_data_valid_i | input | 1 | Read data returned |
| rd_data_i | input | 32 | Read data |

## Verification
All 32 sub-operation codes are swept over operand pairs chosen for specific purposes. Zero, equal, ascending and descending values separate borrow from no-borrow. All-ones plus one and twice 0x80000000 separate carry-out from none. The enable is toggled so that both incoming carry values reach add-with-carry and subtract-with-borrow. The bitfield sweep crosses sizes 0, 1, 5, 16 and 31 with source and destination positions at 0, a middle value and 31. Two A values give both small and large dynamic shifts. Immediates at 0, ±1 and the two 18-bit extremes test the sign extension, and a read with a stalled ready and a delayed data return tests the request hold and release.

// File: rtl/macro_alu_pkg.sv
package macro_alu_pkg;
  localparam int XLEN     = 32;
  localparam int INSN_W   = 32;
  localparam int SH_W     = $clog2(XLEN);
  localparam int SUB_W    = 5;
  localparam int SUB_LSB  = 17;
  localparam int SIZE_LSB = 22;
  localparam int DST_LSB  = 27;
  localparam int IMM_LSB  = 14;
  localparam int IMM_W    = INSN_W - IMM_LSB;

  typedef enum logic [2:0] {
    PRIM_REGREG = 3'd0,
    PRIM_ADDI   = 3'd1,
    PRIM_BFINS  = 3'd2,
    PRIM_BFX_F  = 3'd3,
    PRIM_BFX_A  = 3'd4,
    PRIM_RDREG  = 3'd5,
    PRIM_RSV    = 3'd6,
    PRIM_BRANCH = 3'd7
  } prim_op_e;

  localparam logic [SUB_W-1:0] SUB_ADD  = 5'd0;
  localparam logic [SUB_W-1:0] SUB_ADC  = 5'd1;
  localparam logic [SUB_W-1:0] SUB_SUB  = 5'd2;
  localparam logic [SUB_W-1:0] SUB_SBB  = 5'd3;
  localparam logic [SUB_W-1:0] SUB_XOR  = 5'd8;
  localparam logic [SUB_W-1:0] SUB_OR   = 5'd9;
  localparam logic [SUB_W-1:0] SUB_AND  = 5'd10;
  localparam logic [SUB_W-1:0] SUB_ANDN = 5'd11;
  localparam logic [SUB_W-1:0] SUB_NAND = 5'd12;
endpackage

// File: rtl/macro_alu_decode.sv
module macro_alu_decode
  import macro_alu_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output prim_op_e          op_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic [XLEN-1:0]   imm_o,
  output logic [SH_W-1:0]   bf_src_o,
  output logic [SH_W-1:0]   bf_size_o,
  output logic [SH_W-1:0]   bf_dst_o,
  output logic              arith_o,
  output logic              read_o,
  output logic              err_o
);
  logic sub_ok;

  always_comb begin
    op_o      = prim_op_e'(insn_i[2:0]);
    sub_o     = insn_i[SUB_LSB +: SUB_W];
    imm_o     = {{(XLEN-IMM_W){insn_i[INSN_W-1]}}, insn_i[INSN_W-1:IMM_LSB]};
    bf_src_o  = insn_i[SUB_LSB  +: SH_W];
    bf_size_o = insn_i[SIZE_LSB +: SH_W];
    bf_dst_o  = insn_i[DST_LSB  +: SH_W];

    case (sub_o)
      SUB_ADD, SUB_ADC, SUB_SUB, SUB_SBB,
      SUB_XOR, SUB_OR, SUB_AND, SUB_ANDN, SUB_NAND: sub_ok = 1'b1;
      default:                                      sub_ok = 1'b0;
    endcase

    err_o   = (op_o == PRIM_RSV) || (op_o == PRIM_BRANCH) ||
              ((op_o == PRIM_REGREG) && !sub_ok);
    arith_o = (op_o == PRIM_REGREG) && (sub_o[SUB_W-1:2] == '0);
    read_o  = (op_o == PRIM_RDREG);
  end
endmodule

// File: rtl/macro_alu_regop.sv
module macro_alu_regop
  import macro_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic             upd_i,
  output logic [XLEN-1:0]  res_o,
  output logic             carry_o
);
  logic            carry_q;
  logic            carry_d;
  logic            cout;
  logic [XLEN:0]   ext_a;
  logic [XLEN:0]   ext_b;
  logic [XLEN:0]   wide;

  always_comb begin
    ext_a = {1'b0, a_i};
    ext_b = {1'b0, b_i};
    wide  = '0;
    res_o = '0;
    cout  = carry_q;
    case (sub_i)
      SUB_ADD: begin
        wide  = ext_a + ext_b;
        res_o = wide[XLEN-1:0];
        cout  = wide[XLEN];
      end
      SUB_ADC: begin
        wide  = ext_a + ext_b + {{XLEN{1'b0}}, carry_q};
        res_o = wide[XLEN-1:0];
        cout  = wide[XLEN];
      end
      SUB_SUB: begin
        wide  = ext_a - ext_b;
        res_o = wide[XLEN-1:0];
        cout  = ~wide[XLEN];
      end
      SUB_SBB: begin
        wide  = ext_a - ext_b - {{XLEN{1'b0}}, ~carry_q};
        res_o = wide[XLEN-1:0];
        cout  = ~wide[XLEN];
      end
      SUB_XOR:  res_o = a_i ^ b_i;
      SUB_OR:   res_o = a_i | b_i;
      SUB_AND:  res_o = a_i & b_i;
      SUB_ANDN: res_o = a_i & ~b_i;
      SUB_NAND: res_o = ~(a_i & b_i);
      default:  res_o = '0;
    endcase
  end

  always_comb begin
    carry_d = upd_i ? cout : carry_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end

  assign carry_o = carry_q;
endmodule

// File: rtl/macro_alu_bitfield.sv
module macro_alu_bitfield
  import macro_alu_pkg::*;
(
  input  prim_op_e         op_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [SH_W-1:0]  src_i,
  input  logic [SH_W-1:0]  size_i,
  input  logic [SH_W-1:0]  dst_i,
  output logic [XLEN-1:0]  res_o
);
  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] field_src;
  logic [XLEN-1:0] field_dyn;
  logic [SH_W-1:0] a_sh;

  always_comb begin
    a_sh      = a_i[SH_W-1:0];
    mask      = (XLEN'(1) << size_i) - XLEN'(1);
    field_src = (b_i >> src_i) & mask;
    field_dyn = (b_i >> a_sh) & mask;
    case (op_i)
      PRIM_BFINS: res_o = (field_src << dst_i) | (a_i & ~(mask << dst_i));
      PRIM_BFX_F: res_o = field_dyn << dst_i;
      PRIM_BFX_A: res_o = field_src << a_sh;
      default:    res_o = '0;
    endcase
  end
endmodule

// File: rtl/macro_alu_rdport.sv
module macro_alu_rdport
  import macro_alu_pkg::*;
#(
  parameter int RD_ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 read_i,
  input  logic [XLEN-1:0]      a_i,
  input  logic [XLEN-1:0]      imm_i,
  output logic                 req_valid_o,
  input  logic                 req_ready_i,
  output logic [RD_ADDR_W-1:0] addr_o,
  input  logic                 data_valid_i,
  output logic                 done_o
);
  logic            pend_q;
  logic            pend_d;
  logic [XLEN-1:0] sum;

  always_comb begin
    sum         = a_i + imm_i;
    addr_o      = sum[RD_ADDR_W-1:0];
    req_valid_o = read_i && !pend_q;
    done_o      = read_i && pend_q && data_valid_i;
    pend_d      = pend_q;
    if (req_valid_o && req_ready_i) pend_d = 1'b1;
    else if (done_o)                pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=> !req_valid_o); // R11
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i && read_i) |=> (req_valid_o || !read_i)); // R11
endmodule

// File: rtl/macro_alu.sv
module macro_alu
  import macro_alu_pkg::*;
#(
  parameter int RD_ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          insn_i,
  input  logic [31:0]          opa_i,
  input  logic [31:0]          opb_i,
  input  logic                 carry_en_i,
  output logic [31:0]          result_o,
  output logic                 result_valid_o,
  output logic                 error_o,
  output logic                 carry_o,
  output logic                 rd_req_valid_o,
  input  logic                 rd_req_ready_i,
  output logic [RD_ADDR_W-1:0] rd_addr_o,
  input  logic                 rd_data_valid_i,
  input  logic [31:0]          rd_data_i
);
  prim_op_e         op;
  logic [SUB_W-1:0] sub;
  logic [XLEN-1:0]  imm;
  logic [SH_W-1:0]  bf_src;
  logic [SH_W-1:0]  bf_size;
  logic [SH_W-1:0]  bf_dst;
  logic             arith;
  logic             is_read;
  logic             err;
  logic             carry_upd;
  logic             rd_done;
  logic [XLEN-1:0]  reg_res;
  logic [XLEN-1:0]  bf_res;

  macro_alu_decode u_dec (
    .insn_i    (insn_i),
    .op_o      (op),
    .sub_o     (sub),
    .imm_o     (imm),
    .bf_src_o  (bf_src),
    .bf_size_o (bf_size),
    .bf_dst_o  (bf_dst),
    .arith_o   (arith),
    .read_o    (is_read),
    .err_o     (err)
  );

  assign carry_upd = carry_en_i && arith && !err;

  macro_alu_regop u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_i     (opa_i),
    .b_i     (opb_i),
    .sub_i   (sub),
    .upd_i   (carry_upd),
    .res_o   (reg_res),
    .carry_o (carry_o)
  );

  macro_alu_bitfield u_bf (
    .op_i   (op),
    .a_i    (opa_i),
    .b_i    (opb_i),
    .src_i  (bf_src),
    .size_i (bf_size),
    .dst_i  (bf_dst),
    .res_o  (bf_res)
  );

  macro_alu_rdport #(.RD_ADDR_W(RD_ADDR_W)) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .read_i       (is_read),
    .a_i          (opa_i),
    .imm_i        (imm),
    .req_valid_o  (rd_req_valid_o),
    .req_ready_i  (rd_req_ready_i),
    .addr_o       (rd_addr_o),
    .data_valid_i (rd_data_valid_i),
    .done_o       (rd_done)
  );

  always_comb begin
    case (op)
      PRIM_REGREG:                     result_o = reg_res;
      PRIM_ADDI:                       result_o = opa_i + imm;
      PRIM_BFINS, PRIM_BFX_F, PRIM_BFX_A: result_o = bf_res;
      PRIM_RDREG:                      result_o = rd_data_i;
      default:                         result_o = '0;
    endcase
    error_o        = err;
    result_valid_o = !err && (is_read ? rd_done : 1'b1);
  end

  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_en_i |=> $stable(carry_o)); // R6
  AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PRIM_REGREG && sub[SUB_W-1:3] != '0) |=> $stable(carry_o)); // R5
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_upd && sub == SUB_ADD) |=> (carry_o == ($past(result_o) < $past(opa_i)))); // R3
  AST_SUB_NOBORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_upd && sub == SUB_SUB) |=> (carry_o == ($past(opa_i) >= $past(opb_i)))); // R4
  AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PRIM_RSV || op == PRIM_BRANCH) |-> (error_o && !result_valid_o)); // R1
  AST_BF_ZERO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PRIM_BFINS && bf_size == '0) |-> (result_o == opa_i)); // R8
  AST_READ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o |-> !result_valid_o); // R11
endmodule

// File: tb/macro_alu_tb.sv
module macro_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] insn, opa, opb, rd_data;
  logic        carry_en, rd_ready, rd_dvalid;
  logic [31:0] result;
  logic        result_valid, error, carry, rd_req;
  logic [31:0] rd_addr;

  int total = 0;
  int bad   = 0;
  bit m_carry = 1'b0;

  always #5 clk = ~clk;

  macro_alu u_dut (
    .clk (clk), .rst_n (rst_n), .insn_i (insn), .opa_i (opa), .opb_i (opb),
    .carry_en_i (carry_en), .result_o (result), .result_valid_o (result_valid),
    .error_o (error), .carry_o (carry), .rd_req_valid_o (rd_req),
    .rd_req_ready_i (rd_ready), .rd_addr_o (rd_addr),
    .rd_data_valid_i (rd_dvalid), .rd_data_i (rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_reg(input int sub, input logic [31:0] a, input logic [31:0] b, input bit en);
    logic [32:0] w;
    logic [33:0] lhs, rhs;
    logic [31:0] exp_r;
    bit exp_c, exp_err, arith;
    exp_r = 32'h0; exp_c = m_carry; exp_err = 1'b0; arith = 1'b0;
    case (sub)
      0: begin w = {1'b0, a} + {1'b0, b}; exp_r = w[31:0]; exp_c = w[32]; arith = 1; end
      1: begin w = {1'b0, a} + {1'b0, b} + 33'(m_carry); exp_r = w[31:0]; exp_c = w[32]; arith = 1; end
      2: begin exp_r = a - b; exp_c = (a >= b); arith = 1; end
      3: begin
           exp_r = a - b - (m_carry ? 32'd0 : 32'd1);
           lhs = {2'b0, a}; rhs = {2'b0, b} + (m_carry ? 34'd0 : 34'd1);
           exp_c = (lhs >= rhs); arith = 1;
         end
      8:  exp_r = a ^ b;
      9:  exp_r = a | b;
      10: exp_r = a & b;
      11: exp_r = a & ~b;
      12: exp_r = ~(a & b);
      default: exp_err = 1'b1;
    endcase
    @(negedge clk);
    insn = (32'(sub) << 17) | 32'h0000_0500;
    opa = a; opb = b; carry_en = en;
    #1;
    chk(error == exp_err, exp_err ? "R2 error" : "R2 no error", 32'(error), 32'(exp_err));
    chk(result_valid == !exp_err, "R12 valid", 32'(result_valid), 32'(!exp_err));
    if (!exp_err)
      chk(result == exp_r, (sub < 2) ? "R3 sum" : (sub < 4) ? "R4 diff" : "R5 logic",
          result, exp_r);
    @(posedge clk); #1;
    if (en && arith) m_carry = exp_c;
    chk(carry == m_carry, arith ? (en ? "R3/R4 carry" : "R6 carry hold") : "R5 R6 carry kept",
        32'(carry), 32'(m_carry));
  endtask

  task automatic run_bf(input int op, input int src, input int size, input int dst,
                        input logic [31:0] a, input logic [31:0] b);
    logic [31:0] m, e;
    m = (32'd1 << size) - 32'd1;
    case (op)
      2: e = (((b >> src) & m) << dst) | (a & ~(m << dst));
      3: e = ((b >> a[4:0]) & m) << dst;
      default: e = ((b >> src) & m) << a[4:0];
    endcase
    @(negedge clk);
    insn = (32'(dst) << 27) | (32'(size) << 22) | (32'(src) << 17) | 32'(op);
    opa = a; opb = b; carry_en = 1'b0;
    #1;
    chk(result == e && result_valid && !error,
        (op == 2) ? "R8 insert" : (op == 3) ? "R9 extract by field" : "R10 extract by A",
        result, e);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pa [6];
    logic [31:0] pb [6];
    logic [17:0] imms [5];
    logic [31:0] sx;
    int srcs [3];
    int sizes [5];
    int dsts [3];
    pa = '{32'h0, 32'hFFFF_FFFF, 32'h5, 32'h7, 32'h8000_0000, 32'hFFFF_FFFF};
    pb = '{32'h0, 32'h1, 32'h7, 32'h5, 32'h8000_0000, 32'hFFFF_FFFF};
    imms = '{18'h0, 18'h1, 18'h3FFFF, 18'h1FFFF, 18'h20000};
    srcs = '{0, 3, 31};
    sizes = '{0, 1, 5, 16, 31};
    dsts = '{0, 4, 31};

    rst_n = 1'b0; insn = 32'h0; opa = 32'h0; opb = 32'h0; carry_en = 1'b0;
    rd_ready = 1'b0; rd_dvalid = 1'b0; rd_data = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    chk(carry == 1'b0, "R6 reset carry", 32'(carry), 32'h0);
    chk(rd_req == 1'b0, "R11 reset no request", 32'(rd_req), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1: reserved and branch primary codes
    for (int c = 6; c < 8; c++) begin
      @(negedge clk); insn = 32'(c); #1;
      chk(error && !result_valid, "R1 bad primary", {30'h0, error, result_valid}, 32'h2);
    end

    // R2 R3 R4 R5 R6: sub-operation sweep
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 6; p++)
        run_reg(s, pa[p], pb[p], ((s + p) % 3) != 0);

    // R7: add immediate
    for (int i = 0; i < 5; i++)
      for (int p = 0; p < 6; p++) begin
        @(negedge clk);
        insn = (32'(imms[i]) << 14) | 32'h1; opa = pa[p]; carry_en = 1'b0; #1;
        sx = {{14{imms[i][17]}}, imms[i]};
        chk(result == pa[p] + sx && result_valid, "R7 add immediate", result, pa[p] + sx);
      end

    // R8 R9 R10: bitfield sweep
    for (int op = 2; op < 5; op++)
      for (int si = 0; si < 5; si++)
        for (int ri = 0; ri < 3; ri++)
          for (int di = 0; di < 3; di++) begin
            run_bf(op, srcs[ri], sizes[si], dsts[di], 32'h0000_0025, 32'hA5C3_96F0);
            run_bf(op, srcs[ri], sizes[si], dsts[di], 32'hDEAD_BEEF, 32'h1234_5678);
          end

    // R11: register read with stalled ready and delayed data
    @(negedge clk);
    insn = (32'h3FFFC << 14) | 32'h5; opa = 32'h0000_0100; rd_ready = 1'b0; #1;
    chk(rd_req == 1'b1, "R11 request raised", 32'(rd_req), 32'h1);
    chk(rd_addr == 32'h0000_00FC, "R11 address", rd_addr, 32'h0000_00FC);
    chk(result_valid == 1'b0, "R11 no early result", 32'(result_valid), 32'h0);
    @(negedge clk); #1;
    chk(rd_req == 1'b1, "R11 request held", 32'(rd_req), 32'h1);
    @(negedge clk); rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0; #1;
    chk(rd_req == 1'b0, "R11 request dropped", 32'(rd_req), 32'h0);
    chk(result_valid == 1'b0, "R11 waiting for data", 32'(result_valid), 32'h0);
    @(negedge clk); rd_dvalid = 1'b1; rd_data = 32'hCAFE_0042; #1;
    chk(result_valid && result == 32'hCAFE_0042, "R11 read data", result, 32'hCAFE_0042);
    @(negedge clk); rd_dvalid = 1'b0; insn = 32'h0; #1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule